// File: doc/BRIEF.md
# Source Power Path Enable with Timed Fault Recovery

This block decides whether the source side of a Type-C port may drive power onto VBUS. It takes the connection state reported by the CC detection logic, the results of the supply undervoltage and overvoltage comparators, and the VBUS window and presence comparators. From these it drives a registered, active-low enable for the external power switch. Each supply check and the VBUS window check can be turned on or off by its own enable input. Only the supply checks gate the first assertion. After the switch is on, the block watches VBUS alone.

When a hardware fault is seen, the block runs a fixed recovery episode. Fault sources include over-temperature, an invalid pull-up rail, CC overvoltage, VBUS leaving its window while power is on, and a supply limit violation while attached. During the episode, power is withdrawn and the CC terminations are asked to be removed. This lasts for a parameterised number of millisecond ticks, 25 by default. At the end, a one-cycle pulse tells the CC state machine to go back to the unattached source state. Faults that arrive while an episode is running are ignored.

Top module: `pwr_path_ctrl`

## Requirements
- R1: The enable (`pwr_en_n` low) can only be asserted when `conn_state` is 1 (attached source), 2 (unoriented debug accessory) or 3 (oriented debug accessory). For code 0 (unattached), code 4 (audio accessory) and the unused codes 5 to 7, `pwr_en_n` stays high.
- R2: The enable can first be asserted only if two supply conditions hold. When `sup_uv_chk_en` is set, `sup_above_uv` must be 1. When `sup_ov_chk_en` is set, `sup_below_ov` must be 1. A check whose enable bit is clear has no effect.
- R3: When `vbus_win_chk_en` is 1, assertion needs `vbus_in_window`. When it is 0, assertion needs `vbus_present`.
- R4: The enable is a registered output. It follows its conditions one clock edge later, and it drops on the first edge after the connection-state or VBUS condition fails.
- R5: While the enable is asserted, later supply comparator failures neither drop it nor start recovery.
- R6: Recovery starts on the edge after any of these conditions: `flt_over_temp`, `flt_pullup_bad`, `flt_cc_ov`, the VBUS condition failing while the enable is on, or an enabled supply check failing while attached with the enable off. On that edge `term_remove` rises and `pwr_en_n` is high.
- R7: Recovery lasts exactly `RECOV_MS` cycles with `ms_tick` high. On the edge that counts the last tick, `term_remove` falls and `recov_done` is high for exactly one cycle.
- R8: Fault inputs that arrive during recovery neither lengthen nor restart the episode.
- R9: Reset is synchronous and active low. While `rst_n` is low, the next edge forces `pwr_en_n` high and clears `term_remove` and `recov_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| conn_state | input | 3 | Connection state code (see R1) |
| sup_uv_chk_en | input | 1 | Enables the supply undervoltage check |
| sup_above_uv | input | 1 | Supply is above its undervoltage threshold |
| sup_ov_chk_en | input | 1 | Enables the supply overvoltage check |
| sup_below_ov | input | 1 | Supply is below its overvoltage threshold |
| vbus_win_chk_en | input | 1 | Selects window check (1) or presence check (0) |
| vbus_in_window | input | 1 | VBUS is inside its valid window |
| vbus_present | input | 1 | VBUS is above its presence threshold |
| flt_over_temp | input | 1 | Over-temperature fault |
| flt_pullup_bad | input | 1 | CC pull-up rail invalid |
| flt_cc_ov | input | 1 | CC pin overvoltage |
| pwr_en_n | output | 1 | Source power path enable, active low |
| term_remove | output | 1 | Request to remove CC terminations |
| recov_done | output | 1 | One-cycle end-of-recovery pulse |

## Verification
Suppose the enable register holds a stale value. Then `pwr_en_n` disagrees with the qualification formula on the very next edge. It also ignores a supply failure that should have blocked it, or a VBUS failure that should have released it.

The recovery counter is only visible through timing. If its state is wrong, the fall of `term_remove` and the `recov_done` pulse arrive a number of ticks off from `RECOV_MS`. A fault that wrongly restarts the counter shows up the same way.

An error in the supervision hand-over appears within one cycle of a supply comparator change made while power is on.

// File: rtl/pwrp_pkg.sv
// Shared types for the source power path controller.
// Assumes the connection state is a 3-bit code produced by the CC state machine.
package pwrp_pkg;

    typedef enum logic [2:0] {
        CONN_NONE     = 3'd0,
        CONN_SRC      = 3'd1,
        CONN_DBG_UNOR = 3'd2,
        CONN_DBG_OR   = 3'd3,
        CONN_AUDIO    = 3'd4
    } conn_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HOLD = 1'b1
    } rec_e;

    typedef struct packed {
        logic over_temp;
        logic pullup_bad;
        logic cc_ov;
    } hw_flt_t;

endpackage

// File: rtl/pwrp_qualify.sv
// Combinational qualification of the power enable.
// Produces the state, supply and VBUS conditions plus a combined fault request.
// Assumes en_on is the current registered enable, which selects supply or VBUS supervision.
module pwrp_qualify
    import pwrp_pkg::*;
(
    input  logic [2:0] conn_state,
    input  logic       uv_en,
    input  logic       above_uv,
    input  logic       ov_en,
    input  logic       below_ov,
    input  logic       win_en,
    input  logic       in_win,
    input  logic       present,
    input  hw_flt_t    hw_flt,
    input  logic       en_on,
    output logic       conn_ok,
    output logic       supply_ok,
    output logic       vbus_ok,
    output logic       fault_hit
);

    logic uv_fail;
    logic ov_fail;

    // Only attached source and the two debug accessory states may carry power.
    always_comb begin
        conn_ok = (conn_state == CONN_SRC) ||
                  (conn_state == CONN_DBG_UNOR) ||
                  (conn_state == CONN_DBG_OR);
    end

    // Each supply comparator counts only when its check is enabled.
    always_comb begin
        uv_fail   = uv_en & ~above_uv;
        ov_fail   = ov_en & ~below_ov;
        supply_ok = ~uv_fail & ~ov_fail;
    end

    // The VBUS condition is either the full window or plain presence.
    always_comb begin
        vbus_ok = win_en ? in_win : present;
    end

    // Any hardware flag, VBUS loss while powered, or supply failure before power.
    always_comb begin
        fault_hit = hw_flt.over_temp | hw_flt.pullup_bad | hw_flt.cc_ov |
                    (en_on & conn_ok & ~vbus_ok) |
                    (~en_on & conn_ok & (uv_fail | ov_fail));
    end

endmodule

// File: rtl/pwrp_recovery.sv
// Timed error-recovery sequencer.
// Once a fault request is accepted, it holds busy for RECOV_MS millisecond ticks,
// then issues a one-cycle done pulse. Requests are ignored while busy.
// Assumes ms_tick is a single-cycle pulse synchronous to clk.
module pwrp_recovery
    import pwrp_pkg::*;
#(
    parameter int RECOV_MS = 25,
    localparam int CNT_W   = $clog2(RECOV_MS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic fault_req,
    output logic busy,
    output logic done_pulse
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(RECOV_MS - 1);

    rec_e             state_q;
    logic [CNT_W-1:0] tick_cnt_q;
    logic             last_tick;

    assign last_tick = ms_tick && (tick_cnt_q == LAST_TICK);

    // Episode state, tick counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            tick_cnt_q <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            case (state_q)
                RS_IDLE: begin
                    tick_cnt_q <= '0;
                    if (fault_req) begin
                        state_q <= RS_HOLD;
                    end
                end
                RS_HOLD: begin
                    if (last_tick) begin
                        state_q    <= RS_IDLE;
                        tick_cnt_q <= '0;
                        done_pulse <= 1'b1;
                    end else if (ms_tick) begin
                        tick_cnt_q <= tick_cnt_q + 1'b1;
                    end
                end
                default: state_q <= RS_IDLE;
            endcase
        end
    end

    assign busy = (state_q == RS_HOLD);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tick_cnt_q < CNT_W'(RECOV_MS))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ms_tick) |=> (busy && $stable(tick_cnt_q))); // R8
    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(busy)); // R7

endmodule

// File: rtl/pwr_path_ctrl.sv
// Source power path enable with fault recovery (top).
// Registers an active-low power enable from the state, supply and VBUS checks.
// Supervision moves from the supply to VBUS once the enable is on.
// Forwards faults to the recovery sequencer.
// Assumes all inputs are synchronous to clk.
module pwr_path_ctrl
    import pwrp_pkg::*;
#(
    parameter int RECOV_MS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic [2:0] conn_state,
    input  logic       sup_uv_chk_en,
    input  logic       sup_above_uv,
    input  logic       sup_ov_chk_en,
    input  logic       sup_below_ov,
    input  logic       vbus_win_chk_en,
    input  logic       vbus_in_window,
    input  logic       vbus_present,
    input  logic       flt_over_temp,
    input  logic       flt_pullup_bad,
    input  logic       flt_cc_ov,
    output logic       pwr_en_n,
    output logic       term_remove,
    output logic       recov_done
);

    hw_flt_t hw_flt;
    logic    conn_ok;
    logic    supply_ok;
    logic    vbus_ok;
    logic    fault_hit;
    logic    rec_busy;
    logic    en_on_q;
    logic    en_d;

    assign hw_flt = '{over_temp: flt_over_temp, pullup_bad: flt_pullup_bad, cc_ov: flt_cc_ov};

    pwrp_qualify u_qual (
        .conn_state (conn_state),
        .uv_en      (sup_uv_chk_en),
        .above_uv   (sup_above_uv),
        .ov_en      (sup_ov_chk_en),
        .below_ov   (sup_below_ov),
        .win_en     (vbus_win_chk_en),
        .in_win     (vbus_in_window),
        .present    (vbus_present),
        .hw_flt     (hw_flt),
        .en_on      (en_on_q),
        .conn_ok    (conn_ok),
        .supply_ok  (supply_ok),
        .vbus_ok    (vbus_ok),
        .fault_hit  (fault_hit)
    );

    pwrp_recovery #(
        .RECOV_MS (RECOV_MS)
    ) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .fault_req  (fault_hit),
        .busy       (rec_busy),
        .done_pulse (recov_done)
    );

    // Next enable: supply gates only the first assertion, VBUS gates always.
    always_comb begin
        en_d = ~rec_busy & ~fault_hit & conn_ok & vbus_ok & (en_on_q | supply_ok);
    end

    // Glitch-free registered enable, forced off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_on_q <= 1'b0;
        end else begin
            en_on_q <= en_d;
        end
    end

    assign pwr_en_n    = ~en_on_q;
    assign term_remove = rec_busy;

    AST_EN_ONLY_ATTACHED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_n |-> $past(conn_ok)); // R1
    AST_FIRST_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_n) |-> $past(supply_ok)); // R2
    AST_ON_NEEDS_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_n |-> $past(vbus_ok)); // R3
    AST_FAULT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_hit && !rec_busy) |=> (term_remove && pwr_en_n)); // R6
    AST_OFF_IN_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        term_remove |-> pwr_en_n); // R6
    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (pwr_en_n && !term_remove && !recov_done)); // R9

endmodule

// File: tb/tb_pwr_path_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_path_ctrl;

    localparam int RMS = 25;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ms_tick;
    logic [2:0] conn_state;
    logic       sup_uv_chk_en, sup_above_uv, sup_ov_chk_en, sup_below_ov;
    logic       vbus_win_chk_en, vbus_in_window, vbus_present;
    logic       flt_over_temp, flt_pullup_bad, flt_cc_ov;
    logic       pwr_en_n, term_remove, recov_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwr_path_ctrl #(.RECOV_MS(RMS)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .conn_state(conn_state),
        .sup_uv_chk_en(sup_uv_chk_en), .sup_above_uv(sup_above_uv),
        .sup_ov_chk_en(sup_ov_chk_en), .sup_below_ov(sup_below_ov),
        .vbus_win_chk_en(vbus_win_chk_en), .vbus_in_window(vbus_in_window),
        .vbus_present(vbus_present), .flt_over_temp(flt_over_temp),
        .flt_pullup_bad(flt_pullup_bad), .flt_cc_ov(flt_cc_ov),
        .pwr_en_n(pwr_en_n), .term_remove(term_remove), .recov_done(recov_done)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_inputs();
        ms_tick = 0; conn_state = 3'd0;
        sup_uv_chk_en = 0; sup_above_uv = 0; sup_ov_chk_en = 0; sup_below_ov = 0;
        vbus_win_chk_en = 0; vbus_in_window = 0; vbus_present = 0;
        flt_over_temp = 0; flt_pullup_bad = 0; flt_cc_ov = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // one clock edge, then sample at the following falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1;
            @(negedge clk);
            ms_tick = 0;
        end
    endtask

    // attached source, window check on, all good -> enable on
    task automatic power_up();
        do_reset();
        conn_state = 3'd1;
        sup_uv_chk_en = 1; sup_above_uv = 1;
        sup_ov_chk_en = 1; sup_below_ov = 1;
        vbus_win_chk_en = 1; vbus_in_window = 1; vbus_present = 1;
        step();
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: reset state
        clear_inputs();
        rst_n = 0;
        step(); step();
        chk("R9 reset en", pwr_en_n, 1'b1);
        chk("R9 reset term", term_remove, 1'b0);
        chk("R9 reset done", recov_done, 1'b0);

        // R1 R2 R3: sweep of connection codes and comparator/enable combinations
        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 128; v++) begin
                logic e_conn, e_sup, e_vb;
                do_reset();
                conn_state      = 3'(c);
                sup_uv_chk_en   = v[0]; sup_above_uv   = v[1];
                sup_ov_chk_en   = v[2]; sup_below_ov   = v[3];
                vbus_win_chk_en = v[4]; vbus_in_window = v[5];
                vbus_present    = v[6];
                e_conn = (c >= 1) && (c <= 3);
                e_sup  = (!v[0] || v[1]) && (!v[2] || v[3]);
                e_vb   = v[4] ? v[5] : v[6];
                step();
                chk("R1 R2 R3 enable qualification", pwr_en_n, !(e_conn && e_sup && e_vb));
                chk("R6 supply fault at attach", term_remove, e_conn && !e_sup);
            end
        end

        // R5: supply failures ignored once powered
        power_up();
        chk("R4 enable after one edge", pwr_en_n, 1'b0);
        sup_above_uv = 0;
        step();
        chk("R5 undervoltage ignored while on", pwr_en_n, 1'b0);
        chk("R5 no recovery on undervoltage", term_remove, 1'b0);
        sup_below_ov = 0;
        step();
        chk("R5 overvoltage ignored while on", pwr_en_n, 1'b0);

        // R4 R6 R7: VBUS leaves window -> drop and timed recovery
        vbus_in_window = 0;
        step();
        chk("R4 drop on vbus loss", pwr_en_n, 1'b1);
        chk("R6 recovery on vbus loss", term_remove, 1'b1);
        conn_state = 3'd0;
        ticks(RMS - 1);
        chk("R7 still recovering before last tick", term_remove, 1'b1);
        chk("R7 no early done", recov_done, 1'b0);
        ticks(1);
        chk("R7 done on last tick", recov_done, 1'b1);
        chk("R7 terminations restored", term_remove, 1'b0);
        step();
        chk("R7 done is one cycle", recov_done, 1'b0);

        // R4: leaving the attached state drops without recovery
        power_up();
        conn_state = 3'd4;
        step();
        chk("R4 drop on detach", pwr_en_n, 1'b1);
        chk("R4 no recovery on detach", term_remove, 1'b0);

        // R3: presence-only mode drop
        power_up();
        vbus_win_chk_en = 0; vbus_in_window = 0;
        step();
        chk("R3 presence mode keeps enable", pwr_en_n, 1'b0);
        vbus_present = 0;
        step();
        chk("R3 drop on presence loss", pwr_en_n, 1'b1);

        // R6: each hardware flag, both unattached and powered
        for (int f = 0; f < 3; f++) begin
            for (int p = 0; p < 2; p++) begin
                if (p == 1) power_up(); else do_reset();
                flt_over_temp  = (f == 0);
                flt_pullup_bad = (f == 1);
                flt_cc_ov      = (f == 2);
                step();
                chk("R6 hardware flag starts recovery", term_remove, 1'b1);
                chk("R6 enable off in recovery", pwr_en_n, 1'b1);
            end
        end

        // R8: faults during recovery do not extend it
        do_reset();
        flt_over_temp = 1;
        step();
        chk("R8 entered", term_remove, 1'b1);
        ticks(10);
        flt_cc_ov = 1; flt_pullup_bad = 1;
        ticks(RMS - 11);
        flt_over_temp = 0; flt_cc_ov = 0; flt_pullup_bad = 0;
        chk("R8 still holding", term_remove, 1'b1);
        ticks(1);
        chk("R8 done on schedule", recov_done, 1'b1);
        chk("R8 ended", term_remove, 1'b0);

        // R9: reset while powered
        power_up();
        rst_n = 0;
        step();
        chk("R9 reset drops enable", pwr_en_n, 1'b1);
        rst_n = 1;

        finish_run();
    end

endmodule